// File: doc/BRIEF.md
# Split Priority / Round-Robin Channel Arbiter

This block picks which of 256 channels is served next by a shared service engine, such as a DMA mover. A 2-bit split selector decides how many of the lowest-numbered channels form a strict-priority group. Inside that group, the lowest channel number wins. Every other channel belongs to a round-robin group, and that group only gets service when no priority-group channel is asking.

The grant is combinational. It is taken from the request vector, the split selector and one stored round-robin pointer. The engine takes the grant by pulsing the accept strobe in the same cycle. A round-robin pointer exists for the whole block. It only moves when a round-robin grant is accepted.

When the split selector changes, the pointer returns to the first channel of the new round-robin group. The grant in that same cycle already uses the returned pointer. The receive path and the transmit path each use their own instance and their own selector.

Top module: `hyb_arb`

## Requirements
- R1: Bit k of `req` stands for channel k+1, and `gnt_chan` reports the granted channel as its number minus one. `gnt_valid` is high in the same cycle exactly when any request bit is high. A granted channel always has its request bit set.
- R2: The split selector encodes the groups as follows.
  - 2'b00: no priority group; channels 1..256 round robin.
  - 2'b01: channels 1..2 priority; 3..256 round robin.
  - 2'b10: channels 1..16 priority; 17..256 round robin.
  - 2'b11: channels 1..64 priority; 65..256 round robin.
- R3: Within the priority group, the requesting channel with the lowest number is granted.
- R4: Any request in the priority group wins over every request in the round-robin group.
- R5: With no priority request pending, the grant goes to the first requesting round-robin channel at or above the pointer. If there is none, the search wraps to the lowest requesting channel of the round-robin group.
- R6: When a round-robin grant is accepted, the pointer moves to the channel after the granted one. After channel 256 it wraps to the first channel of the round-robin group.
- R7: The pointer keeps its value in these cases:
  - accept is low;
  - the accepted grant is a priority grant;
  - there is no valid grant.
- R8: A change of the split selector returns the pointer to the first channel of the new round-robin group. This takes effect for the grant in the cycle the change appears.
- R9: Synchronous active-high reset sets the pointer to channel 1 and the stored selector to 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 256 | Pending request per channel, bit k = channel k+1 |
| mode | input | 2 | Split selector |
| accept | input | 1 | Engine takes the current grant |
| gnt_valid | output | 1 | A grant is offered |
| gnt_chan | output | 8 | Granted channel number minus one |

## Verification
The hardest situation to reach from the ports is a selector change that lands while the pointer sits somewhere other than the new group's first channel. The pointer is internal, so the only sign that it was returned is which channel wins next.

The stimulus first walks the pointer deep into one group using accepted round-robin grants. It then switches the selector and presents two requests: one just past the new group start, and one above the old pointer. The returned pointer and the stale one lead to different winners.

Wraps past channel 256, and priority accepts that must leave the pointer alone, are set up the same way with request pairs. Each pair is chosen so that a wrong pointer produces a wrong channel.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam int NCH = 256;
    localparam int CW  = $clog2(NCH);

    localparam int SPLIT_P2  = 2;
    localparam int SPLIT_P16 = 16;
    localparam int SPLIT_P64 = 64;

    typedef logic [CW-1:0] chan_t;

    typedef enum logic [1:0] {
        MODE_ALL_RR = 2'b00,
        MODE_P2     = 2'b01,
        MODE_P16    = 2'b10,
        MODE_P64    = 2'b11
    } split_e;

    typedef struct packed {
        logic  valid;
        logic  is_rr;
        chan_t idx;
    } grant_t;

    // index of the first round-robin channel (= size of the priority group)
    function automatic chan_t split_base(input split_e m);
        case (m)
            MODE_P2:  return chan_t'(SPLIT_P2);
            MODE_P16: return chan_t'(SPLIT_P16);
            MODE_P64: return chan_t'(SPLIT_P64);
            default:  return chan_t'(0);
        endcase
    endfunction

    // index after c, wrapping from the last channel to the group base
    function automatic chan_t ptr_after(input chan_t c, input chan_t base);
        if (int'(c) == NCH - 1) return base;
        return c + chan_t'(1);
    endfunction

endpackage

// File: rtl/lsb_find.sv
module lsb_find #(
    parameter int W   = 256,
    parameter int SEG = 16
) (
    input  logic [W-1:0]         vec,
    output logic                 found,
    output logic [$clog2(W)-1:0] idx
);
    localparam int NSEG = W / SEG;
    localparam int IW   = $clog2(W);
    localparam int SW   = $clog2(SEG);

    logic [NSEG-1:0]   seg_any;
    logic [SW-1:0]     seg_idx [NSEG];

    // first level: lowest set bit inside each segment
    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        logic [SEG-1:0] part;
        assign part       = vec[s*SEG +: SEG];
        assign seg_any[s] = |part;
        always_comb begin
            seg_idx[s] = '0;
            for (int i = SEG - 1; i >= 0; i--) begin
                if (part[i]) seg_idx[s] = SW'(i);
            end
        end
    end

    // second level: lowest segment holding a set bit
    always_comb begin
        idx = '0;
        for (int s = NSEG - 1; s >= 0; s--) begin
            if (seg_any[s]) idx = IW'(s * SEG) + IW'(seg_idx[s]);
        end
    end

    assign found = |seg_any;

endmodule

// File: rtl/rr_pointer.sv
module rr_pointer
    import arb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  mode_chg,
    input  chan_t base,
    input  logic  acc_rr,
    input  chan_t gnt_idx,
    output chan_t ptr_q
);
    chan_t ptr_d;

    always_comb begin
        ptr_d = ptr_q;
        if (acc_rr)        ptr_d = ptr_after(gnt_idx, base);
        else if (mode_chg) ptr_d = base;
    end

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= '0;
        else     ptr_q <= ptr_d;
    end

    // R6: accepted round-robin grant moves pointer past the granted channel
    p_ptr_step_r6: assert property (@(posedge clk) disable iff (rst)
        acc_rr |=> (ptr_q == (int'($past(gnt_idx)) == NCH - 1 ?
                              $past(base) : $past(gnt_idx) + chan_t'(1))));

    // R7: no accepted round-robin grant and no split change -> pointer holds
    p_ptr_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!acc_rr && !mode_chg) |=> $stable(ptr_q));

    // R8: split change without round-robin accept returns pointer to base
    p_mode_return_r8: assert property (@(posedge clk) disable iff (rst)
        (mode_chg && !acc_rr) |=> (ptr_q == $past(base)));

endmodule

// File: rtl/hyb_arb.sv
module hyb_arb
    import arb_pkg::*;
#(
    parameter int SEG = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] req,
    input  logic [1:0]     mode,
    input  logic           accept,
    output logic           gnt_valid,
    output logic [CW-1:0]  gnt_chan
);
    split_e         mode_e, mode_q;
    logic           mode_chg;
    chan_t          base_c, ptr_q, eptr;
    logic [NCH-1:0] prio_mask, from_ptr;
    logic [NCH-1:0] p_req, rr_req, rr_hi;
    logic           p_found, hi_found, all_found;
    chan_t          p_idx, hi_idx, all_idx;
    grant_t         gnt;
    logic           acc_rr;

    assign mode_e   = split_e'(mode);
    assign mode_chg = (mode_e != mode_q);
    assign base_c   = split_base(mode_e);
    assign eptr     = mode_chg ? base_c : ptr_q;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_ALL_RR;
        else     mode_q <= mode_e;
    end

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            prio_mask[i] = (i < int'(base_c));
            from_ptr[i]  = (i >= int'(eptr));
        end
    end

    assign p_req  = req & prio_mask;
    assign rr_req = req & ~prio_mask;
    assign rr_hi  = rr_req & from_ptr;

    lsb_find #(.W(NCH), .SEG(SEG)) u_prio (
        .vec(p_req), .found(p_found), .idx(p_idx));
    lsb_find #(.W(NCH), .SEG(SEG)) u_rr_hi (
        .vec(rr_hi), .found(hi_found), .idx(hi_idx));
    lsb_find #(.W(NCH), .SEG(SEG)) u_rr_wrap (
        .vec(rr_req), .found(all_found), .idx(all_idx));

    always_comb begin
        gnt = '0;
        if (p_found)        gnt = '{valid: 1'b1, is_rr: 1'b0, idx: p_idx};
        else if (hi_found)  gnt = '{valid: 1'b1, is_rr: 1'b1, idx: hi_idx};
        else if (all_found) gnt = '{valid: 1'b1, is_rr: 1'b1, idx: all_idx};
    end

    assign acc_rr    = accept && gnt.valid && gnt.is_rr;
    assign gnt_valid = gnt.valid;
    assign gnt_chan  = gnt.idx;

    rr_pointer u_ptr (
        .clk     (clk),
        .rst     (rst),
        .mode_chg(mode_chg),
        .base    (base_c),
        .acc_rr  (acc_rr),
        .gnt_idx (gnt.idx),
        .ptr_q   (ptr_q)
    );

    // assertion-only: channels strictly below the granted one
    logic [NCH-1:0] below_gnt;
    always_comb begin
        for (int i = 0; i < NCH; i++) below_gnt[i] = (i < int'(gnt_chan));
    end

    // R1: a grant is offered exactly when something is requested
    p_valid_iff_req_r1: assert property (@(posedge clk) disable iff (rst)
        gnt_valid == (|req));

    // R1: granted channel is a requesting one
    p_grant_pending_r1: assert property (@(posedge clk) disable iff (rst)
        gnt_valid |-> req[gnt_chan]);

    // R4: a pending priority-group request keeps the grant in that group
    p_prio_first_r4: assert property (@(posedge clk) disable iff (rst)
        (|(req & prio_mask)) |-> (gnt_valid && gnt_chan < base_c));

    // R3: a priority grant has no lower requesting channel
    p_prio_lowest_r3: assert property (@(posedge clk) disable iff (rst)
        (gnt_valid && gnt_chan < base_c) |-> ((req & below_gnt) == '0));

    // R6: stored pointer never sits in the priority group of the stored split
    p_ptr_in_group_r6: assert property (@(posedge clk) disable iff (rst)
        ptr_q >= split_base(mode_q));

endmodule

// File: tb/tb_hyb_arb.sv
module tb_hyb_arb;
    import arb_pkg::*;

    logic           clk = 1'b0;
    logic           rst;
    logic [NCH-1:0] req;
    logic [1:0]     mode;
    logic           accept;
    logic           gnt_valid;
    logic [CW-1:0]  gnt_chan;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    hyb_arb dut (
        .clk(clk), .rst(rst), .req(req), .mode(mode),
        .accept(accept), .gnt_valid(gnt_valid), .gnt_chan(gnt_chan)
    );

    // channel numbers 1..256, 0 = unused slot; ech = expected channel number
    typedef struct packed {
        logic [1:0] md;
        logic [8:0] a;
        logic [8:0] b;
        logic [8:0] c;
        logic       acc;
        logic       ev;
        logic [8:0] ech;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 9'd0,   9'd0,   9'd0,   1'b1, 1'b0, 9'd0,   4'd1}, // R1 idle
        '{2'd0, 9'd5,   9'd9,   9'd200, 1'b1, 1'b1, 9'd5,   4'd5}, // R5
        '{2'd0, 9'd5,   9'd9,   9'd200, 1'b1, 1'b1, 9'd9,   4'd6}, // R6
        '{2'd0, 9'd5,   9'd9,   9'd200, 1'b1, 1'b1, 9'd200, 4'd6}, // R6
        '{2'd0, 9'd5,   9'd9,   9'd200, 1'b0, 1'b1, 9'd5,   4'd5}, // R5 wrap
        '{2'd0, 9'd5,   9'd9,   9'd200, 1'b1, 1'b1, 9'd5,   4'd7}, // R7
        '{2'd0, 9'd256, 9'd3,   9'd0,   1'b1, 1'b1, 9'd256, 4'd5}, // R5
        '{2'd0, 9'd256, 9'd3,   9'd0,   1'b1, 1'b1, 9'd3,   4'd6}, // R6 wrap
        '{2'd1, 9'd1,   9'd2,   9'd100, 1'b1, 1'b1, 9'd1,   4'd3}, // R3
        '{2'd1, 9'd2,   9'd100, 9'd0,   1'b1, 1'b1, 9'd2,   4'd4}, // R4
        '{2'd1, 9'd100, 9'd50,  9'd0,   1'b1, 1'b1, 9'd50,  4'd2}, // R2
        '{2'd1, 9'd100, 9'd50,  9'd0,   1'b1, 1'b1, 9'd100, 4'd6}, // R6
        '{2'd1, 9'd50,  9'd2,   9'd0,   1'b0, 1'b1, 9'd2,   4'd4}, // R4
        '{2'd1, 9'd50,  9'd0,   9'd0,   1'b1, 1'b1, 9'd50,  4'd5}, // R5
        '{2'd2, 9'd17,  9'd3,   9'd0,   1'b1, 1'b1, 9'd3,   4'd2}, // R2
        '{2'd2, 9'd17,  9'd40,  9'd0,   1'b1, 1'b1, 9'd17,  4'd8}, // R8
        '{2'd2, 9'd17,  9'd40,  9'd0,   1'b1, 1'b1, 9'd40,  4'd6}, // R6
        '{2'd2, 9'd16,  9'd17,  9'd0,   1'b0, 1'b1, 9'd16,  4'd2}, // R2
        '{2'd3, 9'd65,  9'd200, 9'd0,   1'b0, 1'b1, 9'd65,  4'd8}, // R8
        '{2'd3, 9'd64,  9'd65,  9'd0,   1'b1, 1'b1, 9'd64,  4'd2}, // R2
        '{2'd3, 9'd65,  9'd200, 9'd0,   1'b1, 1'b1, 9'd65,  4'd7}, // R7
        '{2'd3, 9'd65,  9'd200, 9'd0,   1'b1, 1'b1, 9'd200, 4'd6}, // R6
        '{2'd3, 9'd3,   9'd65,  9'd0,   1'b1, 1'b1, 9'd3,   4'd2}, // R2
        '{2'd3, 9'd65,  9'd0,   9'd0,   1'b1, 1'b1, 9'd65,  4'd5}, // R5
        '{2'd0, 9'd2,   9'd65,  9'd0,   1'b0, 1'b1, 9'd2,   4'd8}, // R8
        '{2'd0, 9'd65,  9'd2,   9'd0,   1'b1, 1'b1, 9'd2,   4'd5}, // R5
        '{2'd0, 9'd65,  9'd2,   9'd0,   1'b1, 1'b1, 9'd65,  4'd6}, // R6
        '{2'd0, 9'd0,   9'd0,   9'd0,   1'b1, 1'b0, 9'd0,   4'd7}, // R7
        '{2'd0, 9'd65,  9'd2,   9'd0,   1'b1, 1'b1, 9'd2,   4'd7}  // R7
    };

    function automatic logic [NCH-1:0] mk_req(input int a, input int b, input int c);
        logic [NCH-1:0] r = '0;
        if (a != 0) r[a-1] = 1'b1;
        if (b != 0) r[b-1] = 1'b1;
        if (c != 0) r[c-1] = 1'b1;
        return r;
    endfunction

    task automatic drive(input logic [1:0] m, input logic [NCH-1:0] r, input logic a);
        @(negedge clk);
        mode = m; req = r; accept = a;
        #1;
    endtask

    task automatic check(input string tag, input logic ev, input int ech);
        int act_ch;
        act_ch = int'(gnt_chan) + 1;
        total++;
        if (gnt_valid !== ev || (ev && act_ch != ech)) begin
            bad++;
            $display("FAIL %s: valid=%0b chan=%0d expected valid=%0b chan=%0d",
                     tag, gnt_valid, act_ch, ev, ech);
        end
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst = 1'b1; mode = m; req = '0; accept = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        rst = 1'b1; mode = 2'd0; req = '0; accept = 1'b0;
        do_reset(2'd0);

        // R9 / R1: reset state, nothing requested -> no grant
        #1;
        check("R9 reset idle", 1'b0, 0);

        for (int k = 0; k < NV; k++) begin
            drive(TBL[k].md, mk_req(int'(TBL[k].a), int'(TBL[k].b), int'(TBL[k].c)),
                  TBL[k].acc);
            check($sformatf("R%0d row %0d", TBL[k].rq, k), TBL[k].ev, int'(TBL[k].ech));
        end

        // R9: pointer moved to 201, reset must return it to channel 1
        drive(2'd0, mk_req(200, 0, 0), 1'b1);
        check("R6 pre-reset step", 1'b1, 200);
        do_reset(2'd0);
        drive(2'd0, mk_req(5, 250, 0), 1'b0);
        check("R9 pointer after reset", 1'b1, 5);

        // R8: split 2'b11 held through reset, group starts at 65 at once
        do_reset(2'd3);
        drive(2'd3, mk_req(70, 100, 0), 1'b0);
        check("R8 split after reset", 1'b1, 70);

        // R3: every channel requesting under split 2'b11 -> channel 1
        drive(2'd3, '1, 1'b0);
        check("R3 all requesting", 1'b1, 1);

        // R8: change to 2'b00 with all requesting, pointer back to channel 1
        drive(2'd0, '1, 1'b0);
        check("R8 return to all-rr", 1'b1, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule